// File: doc/BRIEF.md
# Guard Timer with Protected Oscillator Mode

This block is a down-counting watchdog for a microcontroller peripheral bus. Software starts it, and refreshes it, by writing anything at all to a kick register. The count is reloaded to all ones and runs down from there. If software stops kicking, the counter underflows and the block raises a one-cycle interrupt or a one-cycle reset request. A mode bit chooses which one. The count clock normally comes from the CPU-side clock enable through a prescaler that divides by 16 or by 128.

A protected mode moves the count source to a free-running internal oscillator. The oscillator arrives as a plain input and passes through a synchroniser. In this mode the counter keeps running while the CPU clock is gated, and requests to halt the clock are dropped. The mode bits sit behind a separate write-enable bit. Once protected mode is set, software cannot leave it.

A control register holds a warm-start flag that power-on reset clears and any control write sets. The low five bits of that register read back the top of the counter. Two reset inputs exist. The power-on reset `rst` clears everything. The system reset `sys_rst` clears everything except the warm-start flag.

Top module: `guard_timer`

## Requirements
- R1: A write to the kick register (address 0) reloads the counter to all ones and starts it, whatever the data value. Repeated kicks postpone underflow.
- R2: In normal mode the counter decrements once per 16 enabled CPU clock cycles when control bit 7 is 0, and once per 128 when it is 1. Underflow therefore follows a kick after 2^CNT_W × divisor enabled cycles.
- R3: Control bit 5 (warm flag) reads 0 after power-on reset. Any control-register write (address 1) sets it. Writing 0 never clears it, and `sys_rst` leaves it set.
- R4: Control bits 4..0 read the five most significant counter bits and ignore writes. Control bit 6 is reserved and reads 0.
- R5: On underflow the block pulses `wdt_rst_req` for one cycle when mode bit 0 (address 2) is 1, and pulses `wdt_irq` for one cycle when it is 0. The two never occur together.
- R6: Writes to the mode register take effect only while protect-enable bit 0 (address 3) is 1. Otherwise they are ignored.
- R7: Setting mode bit 1 (protected mode) selects the synchronised `osc_clk` rising edges as the count source, with no prescaler. A period is 2^CNT_W oscillator edges. Counting starts without a kick and continues while `cpu_clk_en` is 0.
- R8: Writing 1 to bit 0 of the halt register (address 4) pulses `stop_o` in the following cycle. In protected mode this write has no effect.
- R9: Software cannot clear mode bit 1. Only `rst` or `sys_rst` clears it.
- R10: In normal mode the counter stays at its reset value and raises nothing until the first kick.
- R11: `osc_clk` passes through a two-flop synchroniser and an edge detector. In protected mode, underflow follows a kick within 2^CNT_W oscillator periods plus a few system clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Power-on reset, synchronous, active high |
| sys_rst | input | 1 | System reset; leaves the warm flag intact |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for bus_addr, registered |
| cpu_clk_en | input | 1 | CPU-side count clock enable (low in wait, hold or stop) |
| osc_clk | input | 1 | Free-running internal oscillator, asynchronous |
| wdt_irq | output | 1 | One-cycle watchdog interrupt |
| wdt_rst_req | output | 1 | One-cycle reset request to the reset controller |
| stop_o | output | 1 | One-cycle request to stop the CPU clock |

## Verification
The embedded properties take four things for granted:
- `bus_wr`, `bus_addr` and `bus_wdata` are synchronous to `clk`.
- `osc_clk` toggles more slowly than half the system clock, so the edge detector never sees two edges in consecutive cycles.
- A reset pulse is applied before the first meaningful edge.
- Between the resets, software never needs to clear the warm flag or the protected-mode bit.

The stimulus holds to these assumptions. Every bus access is driven on the falling edge of `clk`. The oscillator is a free-running square wave whose period is roughly ten system cycles and is deliberately not a multiple of the clock. Both resets are pulsed only from the bench's directed sequences.

// File: rtl/gt_pkg.sv
package gt_pkg;
  localparam int DATA_W  = 8;
  localparam int ADDR_W  = 3;
  localparam int HI_BITS = 5;

  localparam logic [ADDR_W-1:0] A_KICK = 3'd0;
  localparam logic [ADDR_W-1:0] A_CTRL = 3'd1;
  localparam logic [ADDR_W-1:0] A_MODE = 3'd2;
  localparam logic [ADDR_W-1:0] A_PROT = 3'd3;
  localparam logic [ADDR_W-1:0] A_HALT = 3'd4;

  localparam int CTRL_DIV_BIT  = 7;
  localparam int CTRL_WARM_BIT = 5;
  localparam int MODE_RSEL_BIT = 0;
  localparam int MODE_PROT_BIT = 1;

  typedef struct packed {
    logic prot_mode;
    logic rst_sel;
  } mode_t;
endpackage

// File: rtl/gt_regs.sv
module gt_regs
  import gt_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              sys_rst,
  input  logic              wr,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [HI_BITS-1:0] cnt_hi,
  output logic [DATA_W-1:0] rdata,
  output logic              kick,
  output logic              div_sel,
  output logic              rst_sel,
  output logic              prot_mode,
  output logic              stop_o
);
  logic  warm_q;
  logic  prot_en_q;
  logic  div_q;
  mode_t mode_q;
  logic  wr_ctrl, wr_mode, wr_prot, wr_halt;
  logic  unused_wdata;

  assign unused_wdata = ^wdata[6:2];

  assign kick    = wr && (addr == A_KICK);
  assign wr_ctrl = wr && (addr == A_CTRL);
  assign wr_mode = wr && (addr == A_MODE);
  assign wr_prot = wr && (addr == A_PROT);
  assign wr_halt = wr && (addr == A_HALT);

  // warm flag: only power-on reset clears it
  always_ff @(posedge clk) begin
    if (rst)          warm_q <= 1'b0;
    else if (wr_ctrl) warm_q <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst || sys_rst) begin
      prot_en_q <= 1'b0;
      div_q     <= 1'b0;
      mode_q    <= '0;
      stop_o    <= 1'b0;
    end else begin
      if (wr_ctrl) div_q <= wdata[CTRL_DIV_BIT];
      if (wr_prot) prot_en_q <= wdata[0];
      if (wr_mode && prot_en_q) begin
        mode_q.rst_sel   <= wdata[MODE_RSEL_BIT];
        mode_q.prot_mode <= mode_q.prot_mode | wdata[MODE_PROT_BIT];
      end
      stop_o <= wr_halt && wdata[0] && !mode_q.prot_mode;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata <= '0;
    end else begin
      case (addr)
        A_CTRL:  rdata <= {div_q, 1'b0, warm_q, cnt_hi};
        A_MODE:  rdata <= {6'b0, mode_q.prot_mode, mode_q.rst_sel};
        A_PROT:  rdata <= {7'b0, prot_en_q};
        default: rdata <= '0;
      endcase
    end
  end

  assign div_sel   = div_q;
  assign rst_sel   = mode_q.rst_sel;
  assign prot_mode = mode_q.prot_mode;

  // R3
  warm_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    warm_q |=> warm_q);

  // R9
  prot_sticky_chk: assert property (@(posedge clk) disable iff (rst || sys_rst)
    mode_q.prot_mode |=> mode_q.prot_mode);

  // R6
  mode_lock_chk: assert property (@(posedge clk) disable iff (rst || sys_rst)
    !prot_en_q |=> (mode_q == $past(mode_q)));

  // R8
  halt_block_chk: assert property (@(posedge clk) disable iff (rst || sys_rst)
    mode_q.prot_mode |=> !stop_o);
endmodule

// File: rtl/gt_tickgen.sv
module gt_tickgen #(
  parameter int DIV_LO = 16,
  parameter int DIV_HI = 128,
  parameter int SYNC_N = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic div_sel,
  input  logic cpu_clk_en,
  input  logic osc_clk,
  input  logic prot_mode,
  output logic tick
);
  localparam int PRE_W = $clog2(DIV_HI);

  logic [PRE_W-1:0] pre_q;
  logic [PRE_W-1:0] lim;
  logic             pre_wrap;
  logic [SYNC_N:0]  osc_sr;
  logic             osc_edge;

  // synchroniser stages plus one edge-detect flop
  always_ff @(posedge clk) begin
    if (rst) osc_sr <= '0;
    else     osc_sr <= {osc_sr[SYNC_N-1:0], osc_clk};
  end
  assign osc_edge = osc_sr[SYNC_N-1] & ~osc_sr[SYNC_N];

  assign lim      = div_sel ? PRE_W'(DIV_HI - 1) : PRE_W'(DIV_LO - 1);
  assign pre_wrap = cpu_clk_en && (pre_q >= lim);

  always_ff @(posedge clk) begin
    if (rst || clr)      pre_q <= '0;
    else if (pre_wrap)   pre_q <= '0;
    else if (cpu_clk_en) pre_q <= pre_q + 1'b1;
  end

  assign tick = prot_mode ? osc_edge : pre_wrap;

  // R11
  osc_edge_gap_chk: assert property (@(posedge clk) disable iff (rst)
    (prot_mode && tick) |=> !tick);

  // R2
  pre_hold_chk: assert property (@(posedge clk) disable iff (rst || clr)
    (!cpu_clk_en && !prot_mode) |=> (pre_q == $past(pre_q)));
endmodule

// File: rtl/gt_counter.sv
module gt_counter #(
  parameter int CNT_W = 15
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             kick,
  input  logic             tick,
  input  logic             prot_mode,
  input  logic             rst_sel,
  output logic [CNT_W-1:0] cnt,
  output logic             irq,
  output logic             rreq
);
  localparam logic [CNT_W-1:0] RELOAD = {CNT_W{1'b1}};

  logic run_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt   <= RELOAD;
      run_q <= 1'b0;
      irq   <= 1'b0;
      rreq  <= 1'b0;
    end else begin
      irq  <= 1'b0;
      rreq <= 1'b0;
      if (kick) begin
        cnt   <= RELOAD;
        run_q <= 1'b1;
      end else if ((run_q || prot_mode) && tick) begin
        if (cnt == '0) begin
          cnt  <= RELOAD;
          irq  <= !rst_sel;
          rreq <= rst_sel;
        end else begin
          cnt <= cnt - 1'b1;
        end
      end
    end
  end

  // R1
  kick_reload_chk: assert property (@(posedge clk) disable iff (rst)
    kick |=> (cnt == RELOAD));

  // R5
  out_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(irq && rreq));

  // R5
  irq_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    (irq || rreq) |=> !(irq || rreq));

  // R10
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!run_q && !prot_mode && !kick) |=> (cnt == $past(cnt)));
endmodule

// File: rtl/guard_timer.sv
module guard_timer
  import gt_pkg::*;
#(
  parameter int CNT_W  = 15,
  parameter int DIV_LO = 16,
  parameter int DIV_HI = 128,
  parameter int SYNC_N = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sys_rst,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              cpu_clk_en,
  input  logic              osc_clk,
  output logic              wdt_irq,
  output logic              wdt_rst_req,
  output logic              stop_o
);
  logic             rst_any;
  logic             kick, div_sel, rst_sel, prot_mode, tick;
  logic [CNT_W-1:0] cnt;

  assign rst_any = rst || sys_rst;

  gt_regs u_regs (
    .clk       (clk),
    .rst       (rst),
    .sys_rst   (sys_rst),
    .wr        (bus_wr),
    .addr      (bus_addr),
    .wdata     (bus_wdata),
    .cnt_hi    (cnt[CNT_W-1 -: HI_BITS]),
    .rdata     (bus_rdata),
    .kick      (kick),
    .div_sel   (div_sel),
    .rst_sel   (rst_sel),
    .prot_mode (prot_mode),
    .stop_o    (stop_o)
  );

  gt_tickgen #(.DIV_LO(DIV_LO), .DIV_HI(DIV_HI), .SYNC_N(SYNC_N)) u_tick (
    .clk        (clk),
    .rst        (rst_any),
    .clr        (kick),
    .div_sel    (div_sel),
    .cpu_clk_en (cpu_clk_en),
    .osc_clk    (osc_clk),
    .prot_mode  (prot_mode),
    .tick       (tick)
  );

  gt_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk       (clk),
    .rst       (rst_any),
    .kick      (kick),
    .tick      (tick),
    .prot_mode (prot_mode),
    .rst_sel   (rst_sel),
    .cnt       (cnt),
    .irq       (wdt_irq),
    .rreq      (wdt_rst_req)
  );
endmodule

// File: tb/guard_timer_tb.sv
module guard_timer_tb;
  localparam int CNT_W  = 7;
  localparam int PERIOD = 1 << CNT_W;
  localparam int NV     = 15;

  logic       clk = 1'b0, rst = 1'b1, sys_rst = 1'b0;
  logic       bus_wr = 1'b0;
  logic [2:0] bus_addr = '0;
  logic [7:0] bus_wdata = '0, bus_rdata;
  logic       cpu_clk_en = 1'b1, osc_clk = 1'b0;
  logic       wdt_irq, wdt_rst_req, stop_o;
  int         checks = 0, errors = 0;

  always #10 clk = ~clk;
  always #97 osc_clk = ~osc_clk;

  guard_timer #(.CNT_W(CNT_W)) u_dut (
    .clk(clk), .rst(rst), .sys_rst(sys_rst), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .cpu_clk_en(cpu_clk_en), .osc_clk(osc_clk), .wdt_irq(wdt_irq),
    .wdt_rst_req(wdt_rst_req), .stop_o(stop_o)
  );

  // {req, wr, addr, data, expected read}
  localparam logic [23:0] VEC [NV] = '{
    {4'd4, 1'b0, 3'd1, 8'h00, 8'h1F},  // R4 reset readback
    {4'd6, 1'b0, 3'd2, 8'h00, 8'h00},
    {4'd6, 1'b1, 3'd2, 8'h03, 8'h00},  // R6 locked write
    {4'd6, 1'b0, 3'd2, 8'h00, 8'h00},
    {4'd6, 1'b0, 3'd3, 8'h00, 8'h00},
    {4'd3, 1'b1, 3'd1, 8'hFF, 8'h00},  // R3 sets warm
    {4'd3, 1'b0, 3'd1, 8'h00, 8'hBF},
    {4'd3, 1'b1, 3'd1, 8'h00, 8'h00},  // R3 cannot clear
    {4'd3, 1'b0, 3'd1, 8'h00, 8'h3F},
    {4'd6, 1'b1, 3'd3, 8'h01, 8'h00},
    {4'd6, 1'b0, 3'd3, 8'h00, 8'h01},
    {4'd6, 1'b1, 3'd2, 8'h01, 8'h00},
    {4'd6, 1'b0, 3'd2, 8'h00, 8'h01},
    {4'd6, 1'b1, 3'd2, 8'h00, 8'h00},
    {4'd6, 1'b0, 3'd2, 8'h00, 8'h00}
  };

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic check_rng(input string req, input int act, input int lo, input int hi);
    checks++;
    if (act < lo || act > hi) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d..%0d", req, act, lo, hi);
    end
  endtask

  task automatic bwrite(input logic [2:0] a, input logic [7:0] d);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(posedge clk);
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic bread(input logic [2:0] a, output logic [7:0] d);
    bus_addr = a;
    @(posedge clk);
    @(negedge clk);
    d = bus_rdata;
  endtask

  // counts edges from the current negedge until irq or reset request
  task automatic measure(input int limit, output int n, output logic saw_irq, output logic saw_rr);
    n = 0; saw_irq = 1'b0; saw_rr = 1'b0;
    while (n < limit) begin
      @(posedge clk);
      n++;
      @(negedge clk);
      if (wdt_irq || wdt_rst_req) begin
        saw_irq = wdt_irq; saw_rr = wdt_rst_req;
        break;
      end
    end
  endtask

  initial begin
    #(20 * 200000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] rd;
    int n;
    logic si, sr;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    check("R5 reset irq", int'(wdt_irq), 0);
    check("R5 reset rreq", int'(wdt_rst_req), 0);
    check("R8 reset stop", int'(stop_o), 0);

    for (int i = 0; i < NV; i++) begin
      if (VEC[i][19]) bwrite(VEC[i][18:16], VEC[i][15:8]);
      else begin
        bread(VEC[i][18:16], rd);
        check($sformatf("R%0d table[%0d]", VEC[i][23:20], i), int'(rd), int'(VEC[i][7:0]));
      end
    end

    // R10 idle before first kick
    measure(3000, n, si, sr);
    check("R10 no underflow before kick", int'(si | sr), 0);
    bread(3'd1, rd);
    check("R10 counter idle", int'(rd), 8'h3F);

    // R1 R2 R5 divide by 16, interrupt
    bwrite(3'd0, 8'hA5);
    measure(40000, n, si, sr);
    check("R2 div16 period", n, PERIOD * 16);
    check("R5 irq chosen", int'({si, sr}), 2'b10);
    @(negedge clk);
    check("R5 irq one cycle", int'(wdt_irq), 0);

    // R1 refresh postpones underflow
    bwrite(3'd0, 8'h00);
    measure(1000, n, si, sr);
    check("R1 no underflow before refresh", int'(si | sr), 0);
    bwrite(3'd0, 8'hFF);
    measure(40000, n, si, sr);
    check("R1 period after refresh", n, PERIOD * 16);

    // R4 counter high bits: 40 ticks after kick count is 87
    bwrite(3'd0, 8'h3C);
    repeat (640) @(negedge clk);
    bread(3'd1, rd);
    check("R4 counter readback", int'(rd), 8'h35);

    // R2 divide by 128
    bwrite(3'd1, 8'h80);
    bwrite(3'd0, 8'h11);
    measure(40000, n, si, sr);
    check("R2 div128 period", n, PERIOD * 128);

    // R5 reset request chosen
    bwrite(3'd1, 8'h00);
    bwrite(3'd2, 8'h01);
    bwrite(3'd0, 8'h00);
    measure(40000, n, si, sr);
    check("R5 rreq chosen", int'({si, sr}), 2'b01);
    @(negedge clk);
    check("R5 rreq one cycle", int'(wdt_rst_req), 0);

    // R8 halt honoured in normal mode
    bwrite(3'd4, 8'h01);
    check("R8 stop pulse", int'(stop_o), 1);
    @(negedge clk);
    check("R8 stop one cycle", int'(stop_o), 0);

    // R7 R11 protected mode with CPU clock stopped
    bwrite(3'd2, 8'h02);
    cpu_clk_en = 1'b0;
    bwrite(3'd0, 8'h5A);
    measure(5000, n, si, sr);
    check_rng("R11 osc period latency", n, 1225, 1255);
    check("R7 irq in protected mode", int'({si, sr}), 2'b10);
    bwrite(3'd2, 8'h00);
    bread(3'd2, rd);
    check("R9 protected bit sticky", int'(rd), 8'h02);
    bwrite(3'd4, 8'h01);
    check("R8 halt ignored", int'(stop_o), 0);
    cpu_clk_en = 1'b1;

    // R3 R9 system reset keeps warm flag, clears protected mode
    sys_rst = 1'b1;
    @(negedge clk);
    sys_rst = 1'b0;
    bread(3'd2, rd);
    check("R9 cleared by sys_rst", int'(rd), 8'h00);
    bread(3'd1, rd);
    check("R3 warm survives sys_rst", int'(rd), 8'h3F);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    bread(3'd1, rd);
    check("R3 power-on clears warm", int'(rd), 8'h1F);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule